// File: doc/BRIEF.md
# Fused Multiply-Add Mantissa Core

This block is the arithmetic heart of a single-precision fused multiply-add, for the case where the product is finite and nonzero. It takes two 24-bit mantissas with the hidden bit set and their unbiased exponents, the addend mantissa and exponent, and the effective signs of product and addend after any negation the opcode asks for. Special operands (NaN, infinity, zero products, subnormal pre-normalization) are resolved upstream. The addend may be flagged as zero.

The core forms the exact 48-bit product and never rounds it. It places the product and the addend in a 64-bit working field with the leading one at bit 62, aligns the operand with the smaller exponent, and adds or subtracts. It then normalizes and reduces the result to a 27-bit mantissa: 24 significant bits followed by guard, round and sticky. Every right shift folds the bits it drops into bit 0, so the single rounding done afterwards by a separate rounder is correct. The core is a three-stage pipeline that accepts a new operation on every cycle.

Top module: `fma_core`

## Requirements
- R1: `done` is high exactly three clock edges after `start` was sampled high, once per start; starts on consecutive cycles give results on consecutive cycles in the same order.
- R2: The product exponent is `exp_a + exp_b`. The product is placed in the working field with its leading one at bit 62. When the 48-bit product is 2 or more, the field is shifted right one place and the exponent becomes `exp_a + exp_b + 1`.
- R3: With `add_zero` high, the result is the product field reduced to 27 bits, with `prod_sign` as the sign and the product exponent. The addend mantissa, exponent and sign have no effect.
- R4: The addend goes into the field with its hidden bit at bit 62. The operand with the smaller exponent is shifted right by the exponent difference, and every bit it loses is ORed into bit 0. A difference of 64 or more leaves only that sticky bit. The result exponent is the larger exponent.
- R5: With equal signs the aligned fields are added. A carry into bit 63 shifts the sum right one place with sticky and raises the exponent by one.
- R6: With differing signs the smaller aligned magnitude is subtracted from the larger. The result sign is that of the larger magnitude.
- R7: An exact zero difference gives `res_zero` = 1, `res_man` = 0 and `res_exp` = 0. `res_sign` is equal to `round_down`.
- R8: A nonzero result has `res_man[26]` = 1. The exponent drops by one for each place the field is shifted left to bring its leading one to bit 62.
- R9: The 27-bit mantissa is field bits 62..36. Bit 0 also holds the OR of field bits 35..0.
- R10: While `rst_n` is low, `done` is 0 and every result output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operation valid this cycle |
| exp_a | input | 10 | Unbiased exponent of first factor, signed |
| man_a | input | 24 | Mantissa of first factor, hidden bit at 23 |
| exp_b | input | 10 | Unbiased exponent of second factor, signed |
| man_b | input | 24 | Mantissa of second factor, hidden bit at 23 |
| prod_sign | input | 1 | Effective sign of the product |
| exp_c | input | 10 | Unbiased exponent of addend, signed |
| man_c | input | 24 | Mantissa of addend, hidden bit at 23 |
| add_sign | input | 1 | Effective sign of the addend |
| add_zero | input | 1 | Addend is zero |
| round_down | input | 1 | Rounding mode is toward minus infinity (sign of an exact zero) |
| done | output | 1 | Result valid |
| res_sign | output | 1 | Result sign |
| res_exp | output | 12 | Result exponent, signed, unbiased |
| res_man | output | 27 | Result mantissa with guard, round and sticky |
| res_zero | output | 1 | Result is an exact zero |

## Verification
The bench builds the core with its default parameters: 24-bit mantissas, 10-bit signed exponents and a 12-bit internal exponent. This default exponent range lets directed cases reach alignment shifts larger than the 64-bit field, where only the sticky bit is left. It also lets near-equal exponents cancel deeply, so the left normalization moves the leading one across much of the field. A reference written with one-bit shift loops checks fixed cases, computed by hand, and a stream of pseudo-random operations. It also checks back-to-back issue, and that the addend has no effect when it is flagged as zero.

// File: rtl/fma_pkg.sv
package fma_pkg;

  localparam int FIELD_W = 64;
  localparam int AMT_W   = 16;

  typedef logic [FIELD_W-1:0] field_t;

  // Right shift that ORs every bit pushed out into bit 0 of the result.
  function automatic field_t sticky_shr(input field_t v, input logic [AMT_W-1:0] amt);
    field_t mask;
    field_t res;
    if (amt >= AMT_W'(FIELD_W)) begin
      res    = '0;
      res[0] = |v;
    end else begin
      mask   = ~({FIELD_W{1'b1}} << amt);
      res    = v >> amt;
      res[0] = res[0] | (|(v & mask));
    end
    return res;
  endfunction

  // Zeros above the leading one, counted from bit FIELD_W-2 downward.
  function automatic logic [6:0] lead_zeros(input field_t v);
    logic [6:0] n;
    logic       seen;
    n    = '0;
    seen = 1'b0;
    for (int i = FIELD_W - 2; i >= 0; i--) begin
      if (!seen) begin
        if (v[i]) seen = 1'b1;
        else      n    = n + 7'd1;
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/fma_mul_stage.sv
module fma_mul_stage
  import fma_pkg::*;
#(
  parameter int MAN_W = 24,
  parameter int EXP_W = 10,
  parameter int XW    = EXP_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [EXP_W-1:0] exp_a,
  input  logic        [MAN_W-1:0] man_a,
  input  logic signed [EXP_W-1:0] exp_b,
  input  logic        [MAN_W-1:0] man_b,
  input  logic                    prod_sign,
  input  logic signed [EXP_W-1:0] exp_c,
  input  logic        [MAN_W-1:0] man_c,
  input  logic                    add_sign,
  input  logic                    add_zero,
  input  logic                    round_down,
  output logic                    out_valid,
  output field_t                  p_field,
  output logic signed [XW-1:0]    p_exp,
  output logic                    p_sign,
  output field_t                  z_field,
  output logic signed [XW-1:0]    z_exp,
  output logic                    z_sign,
  output logic                    z_zero,
  output logic                    rd_q
);

  localparam int PROD_W   = 2 * MAN_W;
  localparam int PROD_LSH = FIELD_W - PROD_W;
  localparam int Z_LSH    = FIELD_W - 1 - MAN_W;

  logic [PROD_W-1:0]    prod;
  field_t               prod_wide;
  logic                 prod_carry;
  field_t               prod_norm;
  logic signed [XW-1:0] ea_x, eb_x, ec_x;
  logic signed [XW-1:0] prod_exp;

  assign prod       = man_a * man_b;
  assign prod_wide  = field_t'(prod) << PROD_LSH;
  assign prod_carry = prod_wide[FIELD_W-1];
  assign prod_norm  = prod_carry ? (prod_wide >> 1) : prod_wide;
  assign ea_x       = XW'(exp_a);
  assign eb_x       = XW'(exp_b);
  assign ec_x       = XW'(exp_c);
  assign prod_exp   = ea_x + eb_x + {{(XW-1){1'b0}}, prod_carry};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      p_field   <= '0;
      p_exp     <= '0;
      p_sign    <= 1'b0;
      z_field   <= '0;
      z_exp     <= '0;
      z_sign    <= 1'b0;
      z_zero    <= 1'b0;
      rd_q      <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        p_field <= prod_norm;
        p_exp   <= prod_exp;
        p_sign  <= prod_sign;
        z_field <= field_t'(man_c) << Z_LSH;
        z_exp   <= ec_x;
        z_sign  <= add_sign;
        z_zero  <= add_zero;
        rd_q    <= round_down;
      end
    end
  end

  // R2
  p_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (p_field[FIELD_W-1:FIELD_W-2] == 2'b01));

endmodule

// File: rtl/fma_align_add.sv
module fma_align_add
  import fma_pkg::*;
#(
  parameter int XW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  field_t               p_field,
  input  logic signed [XW-1:0] p_exp,
  input  logic                 p_sign,
  input  field_t               z_field,
  input  logic signed [XW-1:0] z_exp,
  input  logic                 z_sign,
  input  logic                 z_zero,
  input  logic                 rd_q,
  output logic                 s_valid,
  output field_t               s_field,
  output logic signed [XW-1:0] s_exp,
  output logic                 s_sign,
  output logic                 s_zero
);

  logic signed [XW:0]   exp_diff;
  logic                 z_ahead;
  logic        [XW:0]   diff_mag;
  logic [AMT_W-1:0]     align_amt;
  field_t               p_al, z_al;
  logic signed [XW-1:0] big_exp;
  logic                 same_sign;
  field_t               raw_sum;
  logic                 add_carry;
  logic                 p_larger;
  field_t               mag_diff;
  logic                 cancel;

  field_t               nx_field;
  logic signed [XW-1:0] nx_exp;
  logic                 nx_sign;
  logic                 nx_zero;

  assign exp_diff  = {p_exp[XW-1], p_exp} - {z_exp[XW-1], z_exp};
  assign z_ahead   = exp_diff[XW];
  assign diff_mag  = z_ahead ? (-exp_diff) : exp_diff;
  assign align_amt = AMT_W'(diff_mag);
  assign p_al      = z_ahead ? sticky_shr(p_field, align_amt) : p_field;
  assign z_al      = z_ahead ? z_field : sticky_shr(z_field, align_amt);
  assign big_exp   = z_ahead ? z_exp : p_exp;
  assign same_sign = (p_sign == z_sign);
  assign raw_sum   = p_al + z_al;
  assign add_carry = raw_sum[FIELD_W-1];
  assign p_larger  = (p_al > z_al);
  assign mag_diff  = p_larger ? (p_al - z_al) : (z_al - p_al);
  assign cancel    = !same_sign && (mag_diff == '0);

  always_comb begin
    nx_field = p_field;
    nx_exp   = p_exp;
    nx_sign  = p_sign;
    nx_zero  = 1'b0;
    if (!z_zero) begin
      if (same_sign) begin
        nx_sign = p_sign;
        if (add_carry) begin
          nx_field = sticky_shr(raw_sum, AMT_W'(1));
          nx_exp   = big_exp + XW'(1);
        end else begin
          nx_field = raw_sum;
          nx_exp   = big_exp;
        end
      end else if (cancel) begin
        nx_field = '0;
        nx_exp   = '0;
        nx_sign  = rd_q;
        nx_zero  = 1'b1;
      end else begin
        nx_field = mag_diff;
        nx_exp   = big_exp;
        nx_sign  = p_larger ? p_sign : z_sign;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_valid <= 1'b0;
      s_field <= '0;
      s_exp   <= '0;
      s_sign  <= 1'b0;
      s_zero  <= 1'b0;
    end else begin
      s_valid <= in_valid;
      if (in_valid) begin
        s_field <= nx_field;
        s_exp   <= nx_exp;
        s_sign  <= nx_sign;
        s_zero  <= nx_zero;
      end
    end
  end

  // R5
  sum_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && !s_zero |-> !s_field[FIELD_W-1]);

  // R7
  cancel_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_zero |-> (s_field == '0));

  // R6
  sub_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && !s_zero |-> (s_field != '0));

endmodule

// File: rtl/fma_norm_pack.sv
module fma_norm_pack
  import fma_pkg::*;
#(
  parameter int XW    = 12,
  parameter int OUT_W = 27
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  field_t               s_field,
  input  logic signed [XW-1:0] s_exp,
  input  logic                 s_sign,
  input  logic                 s_zero,
  output logic                 done,
  output logic                 res_sign,
  output logic signed [XW-1:0] res_exp,
  output logic [OUT_W-1:0]     res_man,
  output logic                 res_zero
);

  localparam int COMP_SH = FIELD_W - 1 - OUT_W;

  logic [6:0]           lz_cnt;
  field_t               normed;
  field_t               packed_f;
  logic signed [XW-1:0] norm_exp;

  assign lz_cnt   = s_zero ? 7'd0 : lead_zeros(s_field);
  assign normed   = s_field << lz_cnt;
  assign norm_exp = s_exp - XW'(lz_cnt);
  assign packed_f = sticky_shr(normed, AMT_W'(COMP_SH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      res_sign <= 1'b0;
      res_exp  <= '0;
      res_man  <= '0;
      res_zero <= 1'b0;
    end else begin
      done <= in_valid;
      if (in_valid) begin
        res_sign <= s_sign;
        res_zero <= s_zero;
        res_exp  <= s_zero ? '0 : norm_exp;
        res_man  <= s_zero ? '0 : packed_f[OUT_W-1:0];
      end
    end
  end

  // R9
  pack_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (packed_f[FIELD_W-1:OUT_W] == '0));

  // R8
  norm_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !res_zero |-> res_man[OUT_W-1]);

  // R7
  zero_man_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && res_zero |-> (res_man == '0) && (res_exp == '0));

endmodule

// File: rtl/fma_core.sv
module fma_core
  import fma_pkg::*;
#(
  parameter int MAN_W = 24,
  parameter int EXP_W = 10,
  parameter int XW    = EXP_W + 2,
  parameter int OUT_W = MAN_W + 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic signed [EXP_W-1:0] exp_a,
  input  logic        [MAN_W-1:0] man_a,
  input  logic signed [EXP_W-1:0] exp_b,
  input  logic        [MAN_W-1:0] man_b,
  input  logic                    prod_sign,
  input  logic signed [EXP_W-1:0] exp_c,
  input  logic        [MAN_W-1:0] man_c,
  input  logic                    add_sign,
  input  logic                    add_zero,
  input  logic                    round_down,
  output logic                    done,
  output logic                    res_sign,
  output logic signed [XW-1:0]    res_exp,
  output logic [OUT_W-1:0]        res_man,
  output logic                    res_zero
);

  logic                 m_valid;
  field_t               m_pfield, m_zfield;
  logic signed [XW-1:0] m_pexp, m_zexp;
  logic                 m_psign, m_zsign, m_zzero, m_rd;

  logic                 a_valid;
  field_t               a_field;
  logic signed [XW-1:0] a_exp;
  logic                 a_sign, a_zero;

  fma_mul_stage #(.MAN_W(MAN_W), .EXP_W(EXP_W), .XW(XW)) u_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(start),
    .exp_a(exp_a), .man_a(man_a), .exp_b(exp_b), .man_b(man_b),
    .prod_sign(prod_sign), .exp_c(exp_c), .man_c(man_c),
    .add_sign(add_sign), .add_zero(add_zero), .round_down(round_down),
    .out_valid(m_valid), .p_field(m_pfield), .p_exp(m_pexp), .p_sign(m_psign),
    .z_field(m_zfield), .z_exp(m_zexp), .z_sign(m_zsign), .z_zero(m_zzero),
    .rd_q(m_rd)
  );

  fma_align_add #(.XW(XW)) u_add (
    .clk(clk), .rst_n(rst_n), .in_valid(m_valid),
    .p_field(m_pfield), .p_exp(m_pexp), .p_sign(m_psign),
    .z_field(m_zfield), .z_exp(m_zexp), .z_sign(m_zsign), .z_zero(m_zzero),
    .rd_q(m_rd),
    .s_valid(a_valid), .s_field(a_field), .s_exp(a_exp), .s_sign(a_sign),
    .s_zero(a_zero)
  );

  fma_norm_pack #(.XW(XW), .OUT_W(OUT_W)) u_norm (
    .clk(clk), .rst_n(rst_n), .in_valid(a_valid),
    .s_field(a_field), .s_exp(a_exp), .s_sign(a_sign), .s_zero(a_zero),
    .done(done), .res_sign(res_sign), .res_exp(res_exp), .res_man(res_man),
    .res_zero(res_zero)
  );

  // R1
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ##3 done);

  // R1
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start, 3));

  // R7
  zero_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && res_zero |-> (res_sign == $past(round_down, 3)));

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> !done && (res_man == '0));

endmodule

// File: tb/fma_core_bench.sv
`timescale 1ns/1ps
module fma_core_bench;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start = 1'b0;
  logic signed [9:0]  exp_a = '0, exp_b = '0, exp_c = '0;
  logic [23:0]        man_a = '0, man_b = '0, man_c = '0;
  logic               prod_sign = 1'b0, add_sign = 1'b0, add_zero = 1'b0, round_down = 1'b0;
  logic               done, res_sign, res_zero;
  logic signed [11:0] res_exp;
  logic [26:0]        res_man;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  fma_core u_fma_core (
    .clk(clk), .rst_n(rst_n), .start(start),
    .exp_a(exp_a), .man_a(man_a), .exp_b(exp_b), .man_b(man_b),
    .prod_sign(prod_sign), .exp_c(exp_c), .man_c(man_c),
    .add_sign(add_sign), .add_zero(add_zero), .round_down(round_down),
    .done(done), .res_sign(res_sign), .res_exp(res_exp), .res_man(res_man),
    .res_zero(res_zero)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One-bit-at-a-time sticky shift, capped well beyond the field width.
  function automatic logic [63:0] shr_steps(input logic [63:0] v, input int n);
    for (int i = 0; i < n && i < 70; i++) v = (v >> 1) | {63'b0, v[0]};
    return v;
  endfunction

  task automatic ref_model(input int ea, input int eb, input int ec,
                           input logic [23:0] ma, input logic [23:0] mb, input logic [23:0] mc,
                           input logic ps, input logic zs, input logic zz, input logic rd,
                           output logic [26:0] m, output int e, output logic s, output logic z);
    logic [63:0] pf, zf, t;
    int pe, ze;
    pf = 64'(ma) * 64'(mb);
    pf = pf << 16;
    pe = ea + eb;
    if (pf[63]) begin pf = pf >> 1; pe = pe + 1; end
    z = 1'b0;
    if (zz) begin
      t = pf; e = pe; s = ps;
    end else begin
      zf = 64'(mc) << 39;
      ze = ec;
      if (ze > pe) begin pf = shr_steps(pf, ze - pe); pe = ze; end
      else if (pe > ze) begin zf = shr_steps(zf, pe - ze); ze = pe; end
      e = pe;
      if (ps == zs) begin
        t = pf + zf; s = ps;
        if (t[63]) begin t = shr_steps(t, 1); e = e + 1; end
      end else if (pf > zf) begin
        t = pf - zf; s = ps;
      end else begin
        t = zf - pf; s = zs;
      end
      if (t == 64'd0) z = 1'b1;
    end
    if (z) begin
      m = '0; e = 0; s = rd;
    end else begin
      while (!t[62]) begin t = t << 1; e = e - 1; end
      t = shr_steps(t, 36);
      m = t[26:0];
    end
  endtask

  task automatic drive(input int ea, input int eb, input int ec,
                       input logic [23:0] ma, input logic [23:0] mb, input logic [23:0] mc,
                       input logic ps, input logic zs, input logic zz, input logic rd);
    exp_a = 10'(ea); exp_b = 10'(eb); exp_c = 10'(ec);
    man_a = ma; man_b = mb; man_c = mc;
    prod_sign = ps; add_sign = zs; add_zero = zz; round_down = rd;
    start = 1'b1;
  endtask

  task automatic compare(input string req, input logic [26:0] em, input int ee,
                         input logic es, input logic ez);
    check(req, "res_man", longint'(res_man), longint'(em));
    check(req, "res_exp", longint'(res_exp), longint'(ee));
    check(req, "res_sign", longint'(res_sign), longint'(es));
    check(req, "res_zero", longint'(res_zero), longint'(ez));
  endtask

  // Issue one operation, measure the latency and compare with the reference.
  task automatic run_op(input string req, input int ea, input int eb, input int ec,
                        input logic [23:0] ma, input logic [23:0] mb, input logic [23:0] mc,
                        input logic ps, input logic zs, input logic zz, input logic rd);
    logic [26:0] em; int ee; logic es, ez; int cyc;
    ref_model(ea, eb, ec, ma, mb, mc, ps, zs, zz, rd, em, ee, es, ez);
    @(negedge clk);
    drive(ea, eb, ec, ma, mb, mc, ps, zs, zz, rd);
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 8) begin @(negedge clk); cyc++; end
    check("R1", "latency", longint'(cyc), 64'd3);
    compare(req, em, ee, es, ez);
  endtask

  task automatic t_reset;
    // R10: outputs quiet during reset
    check("R10", "done", longint'(done), 64'd0);
    check("R10", "res_man", longint'(res_man), 64'd0);
    check("R10", "res_exp", longint'(res_exp), 64'd0);
  endtask

  task automatic t_hand_cases;
    // R2/R9: 1.0*1.0 + zero addend -> leading one at bit 26
    run_op("R2", 0, 0, 0, 24'h800000, 24'h800000, 24'h0, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R2", "hand man", longint'(res_man), 64'h4000000);
    check("R3", "hand sign", longint'(res_sign), 64'd1);
    // R5: 1*1 + 1 carries into bit 63
    run_op("R5", 0, 0, 0, 24'h800000, 24'h800000, 24'h800000, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R5", "carry exp", longint'(res_exp), 64'd1);
    check("R5", "carry man", longint'(res_man), 64'h4000000);
    // R4: product 100 binades below addend leaves only sticky
    run_op("R4", 0, 0, 100, 24'h800000, 24'h800000, 24'h800000, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R4", "far man", longint'(res_man), 64'h4000001);
    check("R4", "far exp", longint'(res_exp), 64'd100);
    // R6/R8: 1.5 - 1 = 0.5, product larger
    run_op("R6", 0, 0, 0, 24'hC00000, 24'h800000, 24'h800000, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R6", "sign", longint'(res_sign), 64'd1);
    check("R8", "exp", longint'(res_exp), -64'sd1);
    // R6: 2 - 1, addend larger
    run_op("R6", 0, 0, 1, 24'h800000, 24'h800000, 24'h800000, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R6", "addend sign", longint'(res_sign), 64'd0);
    check("R6", "addend exp", longint'(res_exp), 64'd0);
  endtask

  task automatic t_cancel;
    // R7: exact cancellation in both rounding modes
    run_op("R7", 3, -2, 1, 24'h800000, 24'h800000, 24'h800000, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R7", "zero flag rn", longint'(res_zero), 64'd1);
    check("R7", "sign rn", longint'(res_sign), 64'd0);
    run_op("R7", 3, -2, 1, 24'h800000, 24'h800000, 24'h800000, 1'b0, 1'b1, 1'b0, 1'b1);
    check("R7", "sign rd", longint'(res_sign), 64'd1);
  endtask

  task automatic t_zero_addend;
    // R3: with add_zero set, addend fields have no effect
    run_op("R3", 5, -7, 0, 24'hFFFFFF, 24'hFFFFFF, 24'h800000, 1'b0, 1'b1, 1'b1, 1'b0);
    run_op("R3", 5, -7, 90, 24'hFFFFFF, 24'hFFFFFF, 24'hABCDEF, 1'b0, 1'b0, 1'b1, 1'b1);
    // R9: this product carries low bits into the sticky position
    check("R9", "sticky bit", longint'(res_man[0]), 64'd1);
  endtask

  task automatic t_back_to_back;
    logic [26:0] m1, m2; int e1, e2; logic s1, s2, z1, z2;
    ref_model(2, 3, 4, 24'h912345, 24'hA54321, 24'hF00001, 1'b0, 1'b1, 1'b0, 1'b0, m1, e1, s1, z1);
    ref_model(-9, 1, -30, 24'hFFFFFF, 24'h800001, 24'hC00000, 1'b1, 1'b1, 1'b0, 1'b0, m2, e2, s2, z2);
    @(negedge clk);
    drive(2, 3, 4, 24'h912345, 24'hA54321, 24'hF00001, 1'b0, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    drive(-9, 1, -30, 24'hFFFFFF, 24'h800001, 24'hC00000, 1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check("R1", "first done", longint'(done), 64'd1);
    compare("R1", m1, e1, s1, z1);
    @(negedge clk);
    check("R1", "second done", longint'(done), 64'd1);
    compare("R1", m2, e2, s2, z2);
    @(negedge clk);
    check("R1", "done drops", longint'(done), 64'd0);
  endtask

  task automatic t_random;
    for (int k = 0; k < 300; k++) begin
      int ea, eb, ec, mode;
      logic [23:0] ma, mb, mc;
      ea = int'($urandom % 121) - 60;
      eb = int'($urandom % 121) - 60;
      mode = int'($urandom % 4);
      if (mode == 0)      ec = ea + eb + int'($urandom % 5) - 2;
      else if (mode == 1) ec = ea + eb + int'($urandom % 181) - 90;
      else                ec = ea + eb + int'($urandom % 61) - 30;
      ma = 24'($urandom) | 24'h800000;
      mb = 24'($urandom) | 24'h800000;
      mc = (mode == 0 && k[0]) ? 24'h800000 : (24'($urandom) | 24'h800000);
      run_op("R4/R5/R6/R8", ea, eb, ec, ma, mb, mc, 1'($urandom), 1'($urandom),
             ($urandom % 8) == 0, 1'($urandom));
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_hand_cases();
    t_cancel();
    t_zero_addend();
    t_back_to_back();
    t_random();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule